// File: doc/BRIEF.md
# Dual-Stage Watchdog Alarm Controller

This block supervises clock reprogramming with two nested watchdog timeouts, both counted in units of a fixed-length tick, nominally 290 ms. A tick pulse arrives from outside, one system clock wide. A short soft alarm makes a pending CPU PLL band change take effect and pulses the reset output. A long hard alarm also pulses the reset output. It then moves the CPU and AGP/PCI clock sources to safe settings and clears both software N-programming enables.

Software sets the timer limits, the enable bits, the band and select fields, and the safe fallback fields. The block presents the source selection now in force for each PLL as registered outputs. Sticky alarm status bits stay set until the block's synchronous reset. The hardware frequency-select pins are sampled during reset. A hard timeout samples them again when the relatch bit is set.

Top module: `wdg_alarm_ctrl`

## Requirements
- R1: While `rst` is high the block drives `rst_n_o`=1, both status flags 0, both N-programming enables 0 and `cpu_src_o`=0. The pins `hw_fs_i` are sampled during reset. After release, with `cpu_src_o`=0, `cpu_band_o` equals the zero-extended sampled pins and `cpu_cfs_o`=0.
- R2: While `wd_en_i`=1, every tick advances the hard count. The tick that brings the count to `hard_limit_i` sets `hard_flag_o` at the following clock edge. The count then holds. A limit of 0 never fires, and a tick with `wd_en_i`=0 has no effect.
- R3: The soft count behaves the same way against `soft_limit_i`, but advances only while both `wd_en_i` and `soft_en_i` are 1. Its timeout sets `soft_flag_o`.
- R4: Clearing `wd_en_i` zeroes both counts, so after re-enabling, a full limit of ticks is needed again.
- R5: Each alarm drives `rst_n_o` low for exactly RST_PULSE (default 16) clocks, starting at the edge that sets the flag.
- R6: A value written to `band_i` is not used until a soft timeout. At that timeout it is captured as the committed band, which `cpu_band_o` shows while `cpu_src_o`=1.
- R7: A hard timeout clears `cpu_nprog_en_o` and `ap_nprog_en_o`. This takes priority over a write strobe in the same cycle. Otherwise a strobe loads the write data.
- R8: `cpu_src_o` encodes 0 = pins, 1 = software band/select, 2 = watchdog safe band/select. Before any hard timeout it follows `cpu_prog_sel_i` only. After one, {`cpu_safe_mode_i`,`cpu_prog_sel_i`}=00 gives 0, 01 gives 1 and 1x gives 2, with `cpu_band_o`/`cpu_cfs_o` = `wd_band_i`/`wd_cfs_i`.
- R9: `ap_src_o` encodes 0 = fixed 66/33 MHz (`ap_sel_o`=0), 1 = `afs_i`, 2 = `wd_afs_i`. Safe mode is used only after a hard timeout, with the same two-bit rule as R8.
- R10: A hard timeout samples `hw_fs_i` again only when `relatch_en_i`=1. Otherwise the value sampled at reset stays in use.
- R11: Both status flags are sticky. Clearing `wd_en_i` does not clear them, and reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-clock pulse per watchdog time unit |
| wd_en_i | input | 1 | Watchdog enable |
| soft_en_i | input | 1 | Soft alarm enable |
| hard_limit_i | input | HARD_W | Hard timeout in ticks |
| soft_limit_i | input | SOFT_W | Soft timeout in ticks |
| relatch_en_i | input | 1 | Re-sample pins on hard timeout |
| hw_fs_i | input | FS_W | Hardware frequency-select pins |
| band_i | input | BAND_W | Software CPU band (pending) |
| cfs_i | input | SEL_W | Software CPU select within band |
| wd_band_i | input | BAND_W | Safe CPU band |
| wd_cfs_i | input | SEL_W | Safe CPU select |
| cpu_prog_sel_i | input | 1 | CPU source: 0 pins, 1 software |
| cpu_safe_mode_i | input | 1 | CPU safe fallback after hard timeout |
| afs_i | input | SEL_W | Programmed AGP/PCI select |
| wd_afs_i | input | SEL_W | Safe AGP/PCI select |
| ap_prog_sel_i | input | 1 | AGP/PCI source: 0 fixed, 1 programmed |
| ap_safe_mode_i | input | 1 | AGP/PCI safe fallback after hard timeout |
| cpu_nprog_wr_i | input | 1 | Write strobe, CPU N-programming enable |
| cpu_nprog_wdata_i | input | 1 | Write data, CPU N-programming enable |
| ap_nprog_wr_i | input | 1 | Write strobe, AGP/PCI N-programming enable |
| ap_nprog_wdata_i | input | 1 | Write data, AGP/PCI N-programming enable |
| rst_n_o | output | 1 | Active-low reset pulse |
| soft_flag_o | output | 1 | Soft alarm status |
| hard_flag_o | output | 1 | Hard alarm status |
| cpu_src_o | output | 2 | CPU source in force |
| cpu_band_o | output | BAND_W | CPU band in force |
| cpu_cfs_o | output | SEL_W | CPU select in force |
| ap_src_o | output | 2 | AGP/PCI source in force |
| ap_sel_o | output | SEL_W | AGP/PCI select in force |
| cpu_nprog_en_o | output | 1 | CPU N-programming enable |
| ap_nprog_en_o | output | 1 | AGP/PCI N-programming enable |

## Verification
The bound checker watches a set of rules on every cycle. Each flag's rising edge must come with a low `rst_n_o` and must follow the right enables. A hard timeout must leave both N-programming enables clear. The flags must stay sticky, and the CPU source must be the safe one once a hard timeout and safe mode are both present. Some behaviour can only be shown by the bench's scenarios: the exact tick on which each alarm fires, the exact 16-cycle pulse width, the band staying pending until the soft alarm, counter clearing on disable, the zero-limit case, and pin relatching.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    SRC_PINS = 2'd0,
    SRC_PROG = 2'd1,
    SRC_SAFE = 2'd2
  } src_e;
endpackage

// File: rtl/wdg_tick_counter.sv
// Saturating tick counter: fires once when it reaches its limit.
module wdg_tick_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;
  logic         adv;

  assign adv = run && tick && (cnt < limit);
  assign hit = adv && ((cnt + W'(1)) == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (adv)    cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/wdg_pulse_gen.sv
// Active-low pulse of LEN clocks, started (or restarted) by fire.
module wdg_pulse_gen #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse_n
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    if (fire)           cnt_nx = CW'(LEN);
    else if (cnt != '0) cnt_nx = cnt - CW'(1);
    else                cnt_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pulse_n <= 1'b1;
    end else begin
      cnt     <= cnt_nx;
      pulse_n <= (cnt_nx == '0);
    end
  end
endmodule

// File: rtl/wdg_src_select.sv
// Chooses the clock source for each PLL from mode bits and alarm history.
module wdg_src_select
  import wdg_pkg::*;
#(
  parameter int FS_W   = 2,
  parameter int BAND_W = 3,
  parameter int SEL_W  = 3
) (
  input  logic              hard_seen,
  input  logic              cpu_safe,
  input  logic              cpu_prog,
  input  logic              ap_safe,
  input  logic              ap_prog,
  input  logic [FS_W-1:0]   pins,
  input  logic [BAND_W-1:0] prog_band,
  input  logic [SEL_W-1:0]  prog_cfs,
  input  logic [BAND_W-1:0] safe_band,
  input  logic [SEL_W-1:0]  safe_cfs,
  input  logic [SEL_W-1:0]  prog_afs,
  input  logic [SEL_W-1:0]  safe_afs,
  output src_e              cpu_src,
  output logic [BAND_W-1:0] cpu_band,
  output logic [SEL_W-1:0]  cpu_cfs,
  output src_e              ap_src,
  output logic [SEL_W-1:0]  ap_sel
);
  always_comb begin
    if (hard_seen && cpu_safe) begin
      cpu_src  = SRC_SAFE;
      cpu_band = safe_band;
      cpu_cfs  = safe_cfs;
    end else if (cpu_prog) begin
      cpu_src  = SRC_PROG;
      cpu_band = prog_band;
      cpu_cfs  = prog_cfs;
    end else begin
      cpu_src  = SRC_PINS;
      cpu_band = BAND_W'(pins);
      cpu_cfs  = '0;
    end

    if (hard_seen && ap_safe) begin
      ap_src = SRC_SAFE;
      ap_sel = safe_afs;
    end else if (ap_prog) begin
      ap_src = SRC_PROG;
      ap_sel = prog_afs;
    end else begin
      ap_src = SRC_PINS;
      ap_sel = '0;
    end
  end
endmodule

// File: rtl/wdg_alarm_ctrl.sv
module wdg_alarm_ctrl
  import wdg_pkg::*;
#(
  parameter int HARD_W    = 8,
  parameter int SOFT_W    = 4,
  parameter int FS_W      = 2,
  parameter int BAND_W    = 3,
  parameter int SEL_W     = 3,
  parameter int RST_PULSE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wd_en_i,
  input  logic              soft_en_i,
  input  logic [HARD_W-1:0] hard_limit_i,
  input  logic [SOFT_W-1:0] soft_limit_i,
  input  logic              relatch_en_i,
  input  logic [FS_W-1:0]   hw_fs_i,
  input  logic [BAND_W-1:0] band_i,
  input  logic [SEL_W-1:0]  cfs_i,
  input  logic [BAND_W-1:0] wd_band_i,
  input  logic [SEL_W-1:0]  wd_cfs_i,
  input  logic              cpu_prog_sel_i,
  input  logic              cpu_safe_mode_i,
  input  logic [SEL_W-1:0]  afs_i,
  input  logic [SEL_W-1:0]  wd_afs_i,
  input  logic              ap_prog_sel_i,
  input  logic              ap_safe_mode_i,
  input  logic              cpu_nprog_wr_i,
  input  logic              cpu_nprog_wdata_i,
  input  logic              ap_nprog_wr_i,
  input  logic              ap_nprog_wdata_i,
  output logic              rst_n_o,
  output logic              soft_flag_o,
  output logic              hard_flag_o,
  output logic [1:0]        cpu_src_o,
  output logic [BAND_W-1:0] cpu_band_o,
  output logic [SEL_W-1:0]  cpu_cfs_o,
  output logic [1:0]        ap_src_o,
  output logic [SEL_W-1:0]  ap_sel_o,
  output logic              cpu_nprog_en_o,
  output logic              ap_nprog_en_o
);
  logic soft_hit, hard_hit;
  logic [BAND_W-1:0] band_q, band_nx;
  logic [FS_W-1:0]   pins_q, pins_nx;
  logic              hard_nx, soft_nx;
  src_e              cpu_src_nx, ap_src_nx;
  logic [BAND_W-1:0] cpu_band_nx;
  logic [SEL_W-1:0]  cpu_cfs_nx, ap_sel_nx;

  wdg_tick_counter #(.W(HARD_W)) u_hard_cnt (
    .clk(clk), .rst(rst), .run(wd_en_i), .tick(tick_i),
    .limit(hard_limit_i), .hit(hard_hit)
  );

  wdg_tick_counter #(.W(SOFT_W)) u_soft_cnt (
    .clk(clk), .rst(rst), .run(wd_en_i && soft_en_i), .tick(tick_i),
    .limit(soft_limit_i), .hit(soft_hit)
  );

  wdg_pulse_gen #(.LEN(RST_PULSE)) u_pulse (
    .clk(clk), .rst(rst), .fire(soft_hit || hard_hit), .pulse_n(rst_n_o)
  );

  // Next-state of the committed state: band pending until soft alarm,
  // pins re-sampled on hard alarm when asked.
  assign soft_nx = soft_flag_o || soft_hit;
  assign hard_nx = hard_flag_o || hard_hit;
  assign band_nx = soft_hit ? band_i : band_q;
  assign pins_nx = (hard_hit && relatch_en_i) ? hw_fs_i : pins_q;

  wdg_src_select #(.FS_W(FS_W), .BAND_W(BAND_W), .SEL_W(SEL_W)) u_sel (
    .hard_seen(hard_nx),
    .cpu_safe(cpu_safe_mode_i), .cpu_prog(cpu_prog_sel_i),
    .ap_safe(ap_safe_mode_i),   .ap_prog(ap_prog_sel_i),
    .pins(pins_nx),
    .prog_band(band_nx), .prog_cfs(cfs_i),
    .safe_band(wd_band_i), .safe_cfs(wd_cfs_i),
    .prog_afs(afs_i), .safe_afs(wd_afs_i),
    .cpu_src(cpu_src_nx), .cpu_band(cpu_band_nx), .cpu_cfs(cpu_cfs_nx),
    .ap_src(ap_src_nx), .ap_sel(ap_sel_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_flag_o    <= 1'b0;
      hard_flag_o    <= 1'b0;
      band_q         <= '0;
      pins_q         <= hw_fs_i;
      cpu_nprog_en_o <= 1'b0;
      ap_nprog_en_o  <= 1'b0;
      cpu_src_o      <= SRC_PINS;
      cpu_band_o     <= '0;
      cpu_cfs_o      <= '0;
      ap_src_o       <= SRC_PINS;
      ap_sel_o       <= '0;
    end else begin
      soft_flag_o <= soft_nx;
      hard_flag_o <= hard_nx;
      band_q      <= band_nx;
      pins_q      <= pins_nx;
      if (hard_hit)            cpu_nprog_en_o <= 1'b0;
      else if (cpu_nprog_wr_i) cpu_nprog_en_o <= cpu_nprog_wdata_i;
      if (hard_hit)            ap_nprog_en_o  <= 1'b0;
      else if (ap_nprog_wr_i)  ap_nprog_en_o  <= ap_nprog_wdata_i;
      cpu_src_o  <= cpu_src_nx;
      cpu_band_o <= cpu_band_nx;
      cpu_cfs_o  <= cpu_cfs_nx;
      ap_src_o   <= ap_src_nx;
      ap_sel_o   <= ap_sel_nx;
    end
  end
endmodule

// File: rtl/wdg_alarm_ctrl_chk.sv
module wdg_alarm_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wd_en_i,
  input logic       soft_en_i,
  input logic       cpu_safe_mode_i,
  input logic       rst_n_o,
  input logic       soft_flag_o,
  input logic       hard_flag_o,
  input logic [1:0] cpu_src_o,
  input logic       cpu_nprog_en_o,
  input logic       ap_nprog_en_o
);
  a_r5_hard_pulses_reset: assert property (@(posedge clk) disable iff (rst)
    $rose(hard_flag_o) |-> !rst_n_o);
  a_r5_soft_pulses_reset: assert property (@(posedge clk) disable iff (rst)
    $rose(soft_flag_o) |-> !rst_n_o);
  a_r7_nprog_cleared: assert property (@(posedge clk) disable iff (rst)
    $rose(hard_flag_o) |-> (!cpu_nprog_en_o && !ap_nprog_en_o));
  a_r3_soft_needs_enables: assert property (@(posedge clk) disable iff (rst)
    $rose(soft_flag_o) |-> $past(wd_en_i && soft_en_i));
  a_r2_hard_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(hard_flag_o) |-> $past(wd_en_i));
  a_r11_hard_sticky: assert property (@(posedge clk) disable iff (rst)
    hard_flag_o |=> hard_flag_o);
  a_r11_soft_sticky: assert property (@(posedge clk) disable iff (rst)
    soft_flag_o |=> soft_flag_o);
  a_r8_safe_source: assert property (@(posedge clk) disable iff (rst)
    (hard_flag_o && $past(cpu_safe_mode_i)) |-> (cpu_src_o == 2'd2));
endmodule

bind wdg_alarm_ctrl wdg_alarm_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .wd_en_i(wd_en_i), .soft_en_i(soft_en_i),
  .cpu_safe_mode_i(cpu_safe_mode_i), .rst_n_o(rst_n_o),
  .soft_flag_o(soft_flag_o), .hard_flag_o(hard_flag_o),
  .cpu_src_o(cpu_src_o), .cpu_nprog_en_o(cpu_nprog_en_o),
  .ap_nprog_en_o(ap_nprog_en_o)
);

// File: tb/wdg_alarm_ctrl_tb.sv
module wdg_alarm_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 0, wd_en_i = 0, soft_en_i = 0, relatch_en_i = 0;
  logic [7:0] hard_limit_i = 8'd11;
  logic [3:0] soft_limit_i = 4'd2;
  logic [1:0] hw_fs_i = 2'b10;
  logic [2:0] band_i = 0, cfs_i = 0, wd_band_i = 0, wd_cfs_i = 0, afs_i = 0, wd_afs_i = 0;
  logic cpu_prog_sel_i = 0, cpu_safe_mode_i = 0, ap_prog_sel_i = 0, ap_safe_mode_i = 0;
  logic cpu_nprog_wr_i = 0, cpu_nprog_wdata_i = 0, ap_nprog_wr_i = 0, ap_nprog_wdata_i = 0;
  logic rst_n_o, soft_flag_o, hard_flag_o, cpu_nprog_en_o, ap_nprog_en_o;
  logic [1:0] cpu_src_o, ap_src_o;
  logic [2:0] cpu_band_o, cpu_cfs_o, ap_sel_o;

  always #4 clk = ~clk;

  wdg_alarm_ctrl u_dut (.*);

  typedef struct {string req; int sel; int exp;} item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  localparam int S_RSTN = 0, S_SOFT = 1, S_HARD = 2, S_CSRC = 3, S_CBAND = 4,
                 S_CCFS = 5, S_ASRC = 6, S_ASEL = 7, S_CNP = 8, S_ANP = 9;

  function automatic logic [31:0] obs(int sel);
    case (sel)
      S_RSTN:  return 32'(rst_n_o);
      S_SOFT:  return 32'(soft_flag_o);
      S_HARD:  return 32'(hard_flag_o);
      S_CSRC:  return 32'(cpu_src_o);
      S_CBAND: return 32'(cpu_band_o);
      S_CCFS:  return 32'(cpu_cfs_o);
      S_ASRC:  return 32'(ap_src_o);
      S_ASEL:  return 32'(ap_sel_o);
      S_CNP:   return 32'(cpu_nprog_en_o);
      default: return 32'(ap_nprog_en_o);
    endcase
  endfunction

  // Expectation concerns the outputs after the next rising edge.
  task automatic expect_v(string req, int sel, int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_once();
    tick_i = 1'b1; step(); tick_i = 1'b0;
  endtask

  // Monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk); #2;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (obs(it.sel) !== 32'(it.exp)) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, obs(it.sel), it.exp);
        end
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step();
    expect_v("R1", S_RSTN, 1); expect_v("R1", S_SOFT, 0); expect_v("R1", S_HARD, 0);
    expect_v("R1", S_CSRC, 0); expect_v("R1", S_CNP, 0); expect_v("R1", S_ANP, 0);
    step(2);
    rst = 0;
    expect_v("R1", S_CBAND, 2); expect_v("R1", S_CCFS, 0);
    step();
    // Phase A: soft then hard alarm
    hard_limit_i = 5; soft_limit_i = 2; wd_en_i = 1; soft_en_i = 1;
    band_i = 5; cfs_i = 3; cpu_prog_sel_i = 1; cpu_safe_mode_i = 1;
    wd_band_i = 6; wd_cfs_i = 7; ap_prog_sel_i = 1; ap_safe_mode_i = 1;
    afs_i = 4; wd_afs_i = 2;
    cpu_nprog_wr_i = 1; cpu_nprog_wdata_i = 1; ap_nprog_wr_i = 1; ap_nprog_wdata_i = 1;
    expect_v("R8", S_CSRC, 1); expect_v("R6", S_CBAND, 0); expect_v("R8", S_CCFS, 3);
    expect_v("R9", S_ASRC, 1); expect_v("R9", S_ASEL, 4);
    expect_v("R7", S_CNP, 1); expect_v("R7", S_ANP, 1);
    step();
    cpu_nprog_wr_i = 0; ap_nprog_wr_i = 0;
    expect_v("R3", S_SOFT, 0); expect_v("R5", S_RSTN, 1);
    tick_once(); step();
    expect_v("R3", S_SOFT, 1); expect_v("R5", S_RSTN, 0); expect_v("R6", S_CBAND, 5);
    tick_once();
    for (int j = 1; j <= 15; j++) begin
      expect_v("R5", S_RSTN, 0); step();
    end
    expect_v("R5", S_RSTN, 1); step();
    band_i = 1; hw_fs_i = 2'b01;
    expect_v("R6", S_CBAND, 5); step();
    tick_once(); step();
    expect_v("R2", S_HARD, 0);
    tick_once(); step();
    ap_nprog_wr_i = 1; ap_nprog_wdata_i = 1;
    expect_v("R2", S_HARD, 1); expect_v("R5", S_RSTN, 0);
    expect_v("R7", S_CNP, 0); expect_v("R7", S_ANP, 0);
    expect_v("R8", S_CSRC, 2); expect_v("R8", S_CBAND, 6); expect_v("R8", S_CCFS, 7);
    expect_v("R9", S_ASRC, 2); expect_v("R9", S_ASEL, 2);
    tick_once(); ap_nprog_wr_i = 0;
    step(20);
    cpu_safe_mode_i = 0; cpu_prog_sel_i = 0; ap_safe_mode_i = 0; ap_prog_sel_i = 0;
    expect_v("R10", S_CBAND, 2); expect_v("R8", S_CSRC, 0);
    expect_v("R9", S_ASRC, 0); expect_v("R9", S_ASEL, 0);
    step();
    cpu_prog_sel_i = 1;
    expect_v("R8", S_CSRC, 1); expect_v("R6", S_CBAND, 5);
    step();
    wd_en_i = 0;
    step();
    expect_v("R11", S_HARD, 1); expect_v("R11", S_SOFT, 1);
    step();
    // Phase B: disable clears counts, relatch
    rst = 1; step();
    expect_v("R11", S_HARD, 0); expect_v("R11", S_SOFT, 0);
    step();
    rst = 0; hard_limit_i = 3; soft_limit_i = 1; wd_en_i = 1; soft_en_i = 0;
    relatch_en_i = 1; cpu_prog_sel_i = 0; cpu_safe_mode_i = 0;
    expect_v("R1", S_CBAND, 1);
    step();
    expect_v("R3", S_SOFT, 0);
    tick_once(); step();
    tick_once(); step();
    wd_en_i = 0; step(); wd_en_i = 1; step();
    tick_once(); step();
    expect_v("R4", S_HARD, 0);
    tick_once(); step();
    hw_fs_i = 2'b11;
    expect_v("R4", S_HARD, 1); expect_v("R10", S_CBAND, 3);
    tick_once();
    step(20);
    // Phase C: enables gate, zero limit
    rst = 1; step(2); rst = 0;
    hard_limit_i = 0; soft_limit_i = 1; soft_en_i = 1; wd_en_i = 0;
    step();
    tick_once(); step();
    expect_v("R3", S_SOFT, 0); expect_v("R2", S_HARD, 0); step();
    wd_en_i = 1; soft_en_i = 0; step();
    for (int k = 0; k < 3; k++) begin
      tick_once(); step();
    end
    expect_v("R2", S_HARD, 0); expect_v("R5", S_RSTN, 1);
    step(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule